// File: doc/BRIEF.md
# Vehicle Bus Frame Field Parser

This block sits behind a symbol receiver for a single-wire vehicle network. The receiver has already turned pulse widths into symbols. It delivers one strobe per received bit with the bit value, a strobe when a frame opens, a strobe when the inter-frame gap closes a frame, and an error strobe when it sees a symbol it cannot classify. The parser packs bits into bytes and labels each byte. The first four bytes of a frame fill a header register set. Every later byte is a candidate for the data stream.

Only the end-of-frame strobe shows which candidate was the checksum. For that reason, candidates pass through a two-deep holding pipeline. A data byte leaves the block when the byte after the following one arrives. At end-of-frame, the older held byte leaves as the final data byte, and the newer one is reported as the checksum. A CRC is kept over every byte of the frame so that the checksum can be judged pass or fail. A parameter identifier is reported for frames whose mode byte selects it. Short, misaligned and overlong frames raise single-cycle warning pulses.

Top module: `frame_field_parser`

## Requirements
- R1: Bits are packed most significant bit first: the first bit after a frame opens becomes bit 7 of byte 0, and the eighth bit completes the byte.
- R2: Bytes 0, 1, 2 and 3 of a frame are loaded into the priority, destination, source and mode header outputs respectively. The header-valid output rises in the cycle after byte 3 completes and stays high until the next frame opens.
- R3: Bytes from index 4 onward are candidates. Every candidate except the last leaves the block in order on the data output, with one valid pulse per byte. A data byte is released when the byte two places after it completes, or at end-of-frame. The last-data flag is high only on the data byte released at end-of-frame.
- R4: At end-of-frame, the final candidate is presented on the checksum output with a one-cycle valid pulse. The pass flag is 1 exactly when that byte equals the bitwise inverse of a CRC-8 over all earlier bytes of the frame. The CRC uses polynomial 0x1D and initial value 0xFF, is processed most significant bit first, and has no reflection.
- R5: If end-of-frame arrives with no byte after the mode byte, a short-data warning pulses for one cycle. No checksum, data byte or identifier is reported.
- R6: A frame-open strobe discards partially received bits, held candidates and the byte count, and clears header-valid. A frame that follows a partial byte decodes correctly.
- R7: When the mode byte equals 0x01 and at least one candidate exists, the identifier output pulses at end-of-frame and carries the first candidate. With exactly one candidate, that is the checksum-position byte.
- R8: An error strobe discards the frame being assembled. Nothing further is reported for that frame, including at its end-of-frame.
- R9: If end-of-frame arrives while a byte is only partly received, an alignment warning pulses and the frame is discarded, with no checksum and no last-data flag.
- R10: A frame holds at most MAX_BYTES bytes (default 12). Completion of one more byte pulses an overlength warning and discards the frame, so its end-of-frame reports nothing.
- R11: Bit and end-of-frame strobes that arrive while no frame is open have no effect at any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sof_i | input | 1 | Frame-open strobe |
| eof_i | input | 1 | Frame-close strobe (gap seen) |
| err_i | input | 1 | Receiver error strobe |
| bit_vld_i | input | 1 | Bit strobe |
| bit_i | input | 1 | Bit value, taken with bit_vld_i |
| hdr_prio_o | output | 8 | Priority header byte |
| hdr_dst_o | output | 8 | Destination header byte |
| hdr_src_o | output | 8 | Source header byte |
| hdr_mode_o | output | 8 | Mode header byte |
| hdr_vld_o | output | 1 | All four header bytes present |
| dat_o | output | 8 | Data byte |
| dat_vld_o | output | 1 | Data byte valid pulse |
| dat_last_o | output | 1 | Marks the final data byte of a frame |
| cks_o | output | 8 | Checksum byte |
| cks_vld_o | output | 1 | Checksum valid pulse |
| cks_ok_o | output | 1 | Checksum matches inverted CRC |
| pid_o | output | 8 | Parameter identifier byte |
| pid_vld_o | output | 1 | Identifier valid pulse |
| warn_short_o | output | 1 | No candidate byte at end-of-frame |
| warn_align_o | output | 1 | Partial byte at end-of-frame |
| warn_long_o | output | 1 | Frame exceeded MAX_BYTES |

## Verification
A wrong bit count or shift state shows as corrupted header bytes one cycle after the fourth byte, and as a failed checksum or an alignment warning at the same frame's end. A stale holding pipeline shows as a missing, duplicated or reordered data pulse, or as a wrong checksum byte, in the cycle after end-of-frame. Lingering state from an aborted or overlong frame shows as spurious pulses after that frame's end-of-frame. The frame-length sweep covers every count from zero to the limit, with good and bad checksums, so each of these faults reaches a port within one frame.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int FP_BYTE_W = 8;
  localparam int FP_HDR_BYTES = 4;
  typedef logic [FP_BYTE_W-1:0] byte_t;

  // one byte through an MSB-first CRC-8, no reflection
  function automatic byte_t crc8_byte(input byte_t crc, input byte_t data, input byte_t poly);
    byte_t c;
    c = crc ^ data;
    for (int i = 0; i < FP_BYTE_W; i++) begin
      c = c[FP_BYTE_W-1] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/fp_bit_packer.sv
module fp_bit_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              aligned
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d  = {sh_q[BYTE_W-3:0], bit_in};
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign byte_out = {sh_q, bit_in};
  assign byte_stb = shift_en && !clr && (cnt_q == LAST);
  assign aligned  = (cnt_q == '0);

  // R1
  bit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R6
  clr_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> aligned);
endmodule

// File: rtl/fp_crc_track.sv
module fp_crc_track
  import fp_pkg::*;
#(
  parameter byte_t POLY = 8'h1D,
  parameter byte_t INIT = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  upd,
  input  byte_t din,
  output byte_t crc_excl
);
  byte_t all_q, all_d, excl_q, excl_d;

  always_comb begin
    all_d  = all_q;
    excl_d = excl_q;
    if (clr) begin
      all_d  = INIT;
      excl_d = INIT;
    end else if (upd) begin
      excl_d = all_q;
      all_d  = crc8_byte(all_q, din, POLY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_q  <= INIT;
      excl_q <= INIT;
    end else begin
      all_q  <= all_d;
      excl_q <= excl_d;
    end
  end

  assign crc_excl = excl_q;

  // R4
  crc_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> (crc_excl == $past(all_q)));
endmodule

// File: rtl/fp_hold_pipe.sv
module fp_hold_pipe
  import fp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  push,
  input  byte_t din,
  output byte_t newest,
  output byte_t older,
  output logic  newest_v,
  output logic  older_v
);
  byte_t h0_q, h0_d, h1_q, h1_d;
  logic  v0_q, v0_d, v1_q, v1_d;

  always_comb begin
    h0_d = h0_q;
    h1_d = h1_q;
    v0_d = v0_q;
    v1_d = v1_q;
    if (clr) begin
      v0_d = 1'b0;
      v1_d = 1'b0;
    end else if (push) begin
      h1_d = h0_q;
      v1_d = v0_q;
      h0_d = din;
      v0_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q <= '0;
      h1_q <= '0;
      v0_q <= 1'b0;
      v1_q <= 1'b0;
    end else begin
      v0_q <= v0_d;
      v1_q <= v1_d;
      if (push && !clr) begin
        h0_q <= h0_d;
        h1_q <= h1_d;
      end
    end
  end

  assign newest   = h0_q;
  assign older    = h1_q;
  assign newest_v = v0_q;
  assign older_v  = v1_q;

  // R3
  hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    older_v |-> newest_v);
endmodule

// File: rtl/frame_field_parser.sv
module frame_field_parser
  import fp_pkg::*;
#(
  parameter int    MAX_BYTES = 12,
  parameter byte_t CRC_POLY  = 8'h1D,
  parameter byte_t CRC_INIT  = 8'hFF,
  parameter byte_t PID_MODE  = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic       err_i,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  output logic [7:0] hdr_prio_o,
  output logic [7:0] hdr_dst_o,
  output logic [7:0] hdr_src_o,
  output logic [7:0] hdr_mode_o,
  output logic       hdr_vld_o,
  output logic [7:0] dat_o,
  output logic       dat_vld_o,
  output logic       dat_last_o,
  output logic [7:0] cks_o,
  output logic       cks_vld_o,
  output logic       cks_ok_o,
  output logic [7:0] pid_o,
  output logic       pid_vld_o,
  output logic       warn_short_o,
  output logic       warn_align_o,
  output logic       warn_long_o
);
  localparam int IW = $clog2(MAX_BYTES + 1);
  localparam logic [IW-1:0] IDX_MAX  = IW'(MAX_BYTES);
  localparam logic [IW-1:0] IDX_HDR  = IW'(FP_HDR_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic          act_q, act_d;
  logic [IW-1:0] idx_q, idx_d;
  byte_t         first_q;
  logic          hdr_vld_d;

  logic  shift_en, fin, abort, over, cand_push, byte_stb, aligned, good_end;
  byte_t byte_now, h_new, h_old, crc_excl;
  logic  h_new_v, h_old_v;

  logic  dat_vld_d, dat_last_d, cks_vld_d, pid_vld_d;
  logic  w_short_d, w_align_d, w_long_d;
  logic  [FP_HDR_BYTES-1:0] hdr_en;

  always_comb begin
    shift_en  = act_q && bit_vld_i && !sof_i && !err_i && !eof_i;
    abort     = act_q && err_i && !sof_i;
    fin       = act_q && eof_i && !sof_i && !err_i;
    over      = byte_stb && (idx_q == IDX_MAX);
    cand_push = byte_stb && !over && (idx_q >= IDX_HDR);
    good_end  = fin && aligned;

    act_d = act_q;
    if (sof_i)                    act_d = 1'b1;
    else if (abort || fin || over) act_d = 1'b0;

    idx_d = idx_q;
    if (sof_i)                  idx_d = '0;
    else if (byte_stb && !over) idx_d = idx_q + 1'b1;

    for (int k = 0; k < FP_HDR_BYTES; k++)
      hdr_en[k] = byte_stb && (idx_q == IW'(k));

    hdr_vld_d = hdr_vld_o;
    if (sof_i)                            hdr_vld_d = 1'b0;
    else if (hdr_en[FP_HDR_BYTES-1])      hdr_vld_d = 1'b1;

    dat_last_d = good_end && h_old_v;
    dat_vld_d  = (cand_push && h_old_v) || dat_last_d;
    cks_vld_d  = good_end && h_new_v;
    pid_vld_d  = cks_vld_d && hdr_vld_o && (hdr_mode_o == PID_MODE);
    w_short_d  = good_end && !h_new_v;
    w_align_d  = fin && !aligned;
    w_long_d   = over;
  end

  fp_bit_packer #(.BYTE_W(FP_BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_sn), .clr(sof_i), .shift_en(shift_en), .bit_in(bit_i),
    .byte_out(byte_now), .byte_stb(byte_stb), .aligned(aligned)
  );

  fp_crc_track #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_sn), .clr(sof_i), .upd(byte_stb && !over),
    .din(byte_now), .crc_excl(crc_excl)
  );

  fp_hold_pipe u_hold (
    .clk(clk), .rst_n(rst_sn), .clr(sof_i), .push(cand_push), .din(byte_now),
    .newest(h_new), .older(h_old), .newest_v(h_new_v), .older_v(h_old_v)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      act_q        <= 1'b0;
      idx_q        <= '0;
      first_q      <= '0;
      hdr_prio_o   <= '0;
      hdr_dst_o    <= '0;
      hdr_src_o    <= '0;
      hdr_mode_o   <= '0;
      hdr_vld_o    <= 1'b0;
      dat_o        <= '0;
      dat_vld_o    <= 1'b0;
      dat_last_o   <= 1'b0;
      cks_o        <= '0;
      cks_vld_o    <= 1'b0;
      cks_ok_o     <= 1'b0;
      pid_o        <= '0;
      pid_vld_o    <= 1'b0;
      warn_short_o <= 1'b0;
      warn_align_o <= 1'b0;
      warn_long_o  <= 1'b0;
    end else begin
      act_q        <= act_d;
      idx_q        <= idx_d;
      hdr_vld_o    <= hdr_vld_d;
      dat_vld_o    <= dat_vld_d;
      dat_last_o   <= dat_last_d;
      cks_vld_o    <= cks_vld_d;
      pid_vld_o    <= pid_vld_d;
      warn_short_o <= w_short_d;
      warn_align_o <= w_align_d;
      warn_long_o  <= w_long_d;
      if (hdr_en[0]) hdr_prio_o <= byte_now;
      if (hdr_en[1]) hdr_dst_o  <= byte_now;
      if (hdr_en[2]) hdr_src_o  <= byte_now;
      if (hdr_en[3]) hdr_mode_o <= byte_now;
      if (cand_push && idx_q == IDX_HDR) first_q <= byte_now;
      if (dat_vld_d) dat_o <= h_old;
      if (cks_vld_d) begin
        cks_o    <= h_new;
        cks_ok_o <= (h_new == ~crc_excl);
      end
      if (pid_vld_d) pid_o <= first_q;
    end
  end

  // R3
  last_with_cks_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    dat_last_o |-> cks_vld_o);
  // R5
  short_no_cks_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    warn_short_o |-> (!cks_vld_o && !dat_vld_o && !pid_vld_o));
  // R7
  pid_with_cks_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pid_vld_o |-> (cks_vld_o && hdr_mode_o == PID_MODE));
  // R9
  align_discard_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    warn_align_o |-> (!cks_vld_o && !dat_last_o));
  // R10
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    idx_q <= IDX_MAX);
  // R10
  long_closes_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    warn_long_o |-> !act_q);
endmodule

// File: tb/frame_field_parser_test.sv
module frame_field_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_i = 0, eof_i = 0, err_i = 0, bit_vld_i = 0, bit_i = 0;
  logic [7:0] hdr_prio_o, hdr_dst_o, hdr_src_o, hdr_mode_o, dat_o, cks_o, pid_o;
  logic hdr_vld_o, dat_vld_o, dat_last_o, cks_vld_o, cks_ok_o, pid_vld_o;
  logic warn_short_o, warn_align_o, warn_long_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_field_parser #(.MAX_BYTES(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .eof_i(eof_i), .err_i(err_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .hdr_prio_o(hdr_prio_o), .hdr_dst_o(hdr_dst_o), .hdr_src_o(hdr_src_o),
    .hdr_mode_o(hdr_mode_o), .hdr_vld_o(hdr_vld_o),
    .dat_o(dat_o), .dat_vld_o(dat_vld_o), .dat_last_o(dat_last_o),
    .cks_o(cks_o), .cks_vld_o(cks_vld_o), .cks_ok_o(cks_ok_o),
    .pid_o(pid_o), .pid_vld_o(pid_vld_o),
    .warn_short_o(warn_short_o), .warn_align_o(warn_align_o), .warn_long_o(warn_long_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // monitor, sampled 1 time unit after each rising edge
  logic [7:0] m_dat [16];
  int m_nd, m_last, m_lastpos, m_cks, m_pid, m_ws, m_wa, m_wl;
  logic [7:0] m_cksb, m_pidb;
  logic m_ok;

  task automatic clear_mon();
    m_nd = 0; m_last = 0; m_lastpos = -1; m_cks = 0; m_pid = 0;
    m_ws = 0; m_wa = 0; m_wl = 0; m_cksb = 0; m_pidb = 0; m_ok = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (dat_vld_o) begin
      if (m_nd < 16) m_dat[m_nd] = dat_o;
      if (dat_last_o) begin m_last++; m_lastpos = m_nd; end
      m_nd++;
    end
    if (cks_vld_o) begin m_cks++; m_cksb = cks_o; m_ok = cks_ok_o; end
    if (pid_vld_o) begin m_pid++; m_pidb = pid_o; end
    if (warn_short_o) m_ws++;
    if (warn_align_o) m_wa++;
    if (warn_long_o) m_wl++;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] b [16], input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ b[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return c;
  endfunction

  // every task is entered just after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic send_bit(input logic v);
    bit_vld_i = 1; bit_i = v; @(negedge clk); bit_vld_i = 0; bit_i = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic pulse_sof(); sof_i = 1; @(negedge clk); sof_i = 0; endtask
  task automatic pulse_eof(); eof_i = 1; @(negedge clk); eof_i = 0; endtask
  task automatic pulse_err(); err_i = 1; @(negedge clk); err_i = 0; endtask

  logic [7:0] fb [16];

  task automatic build(input int len, input bit good, input int seed);
    for (int i = 0; i < 16; i++) fb[i] = 8'((i * 37 + len * 11 + seed * 5 + 3));
    fb[3] = (len % 2 == 1) ? 8'h01 : 8'h22;
    if (len >= 1) fb[len-1] = ~ref_crc(fb, len - 1) ^ (good ? 8'h00 : 8'h5A);
  endtask

  task automatic run_and_check(input int len, input bit good);
    clear_mon();
    pulse_sof();
    for (int i = 0; i < len; i++) begin
      send_byte(fb[i]);
      if (i % 3 == 2) idle(1);
    end
    if (len >= 4) begin
      // R2 header bytes in order, valid after byte 3
      check("R2 hdr_vld", hdr_vld_o, 1);
      check("R2 prio", hdr_prio_o, fb[0]);
      check("R2 dst", hdr_dst_o, fb[1]);
      check("R2 src", hdr_src_o, fb[2]);
      check("R2 mode", hdr_mode_o, fb[3]);
    end else check("R2 hdr_vld low", hdr_vld_o, 0);
    // R3 before end-of-frame only bytes with two successors are out
    check("R3 early data count", m_nd, (len >= 6) ? len - 6 : 0);
    pulse_eof();
    idle(3);
    if (len <= 4) begin
      check("R5 short warn", m_ws, 1);
      check("R5 no cks", m_cks, 0);
      check("R5 no data", m_nd, 0);
      check("R5 no pid", m_pid, 0);
    end else begin
      check("R5 no short", m_ws, 0);
      check("R3 data count", m_nd, len - 5);
      for (int i = 0; i < len - 5; i++) check("R3 data byte", m_dat[i], fb[4+i]);
      check("R3 last count", m_last, (len >= 6) ? 1 : 0);
      if (len >= 6) check("R3 last pos", m_lastpos, len - 6);
      check("R4 cks count", m_cks, 1);
      check("R4 cks byte", m_cksb, fb[len-1]);
      check("R1 R4 cks ok", m_ok, good);
      check("R7 pid count", m_pid, (fb[3] == 8'h01) ? 1 : 0);
      if (fb[3] == 8'h01) check("R7 pid byte", m_pidb, fb[4]);
    end
    check("R9 no align", m_wa, 0);
    check("R10 no long", m_wl, 0);
  endtask

  initial begin
    clear_mon();
    idle(3);
    rst_n = 1;
    idle(4);
    // reset state
    check("RST hdr_vld", hdr_vld_o, 0);
    check("RST dat_vld", dat_vld_o, 0);
    check("RST cks_vld", cks_vld_o, 0);
    check("RST warns", {warn_short_o, warn_align_o, warn_long_o}, 0);

    // R11 bits and end-of-frame with no frame open
    clear_mon();
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    pulse_eof();
    idle(3);
    check("R11 no output", m_nd + m_cks + m_ws + m_wa + m_wl, 0);
    check("R11 hdr_vld", hdr_vld_o, 0);

    // R1..R5, R7: sweep frame length with good and bad checksum
    for (int len = 0; len <= MAXB; len++) begin
      for (int g = 0; g < 2; g++) begin
        build(len, g[0], g);
        run_and_check(len, g[0]);
      end
    end

    // R6 partial bits before a frame opens are dropped
    build(8, 1, 7);
    pulse_sof();
    send_bit(1); send_bit(0); send_bit(1);
    run_and_check(8, 1);
    check("R6 hdr after restart", hdr_prio_o, fb[0]);

    // R8 error strobe discards the frame
    build(9, 1, 3);
    pulse_sof();
    for (int i = 0; i < 6; i++) send_byte(fb[i]);
    pulse_err();
    idle(2);
    clear_mon();
    send_byte(fb[6]);
    pulse_eof();
    idle(3);
    check("R8 no data", m_nd, 0);
    check("R8 no cks", m_cks, 0);
    check("R8 no warn", m_ws + m_wa + m_wl, 0);

    // R9 partial byte at end-of-frame
    build(7, 1, 4);
    clear_mon();
    pulse_sof();
    for (int i = 0; i < 5; i++) send_byte(fb[i]);
    send_bit(1); send_bit(1); send_bit(0);
    pulse_eof();
    idle(3);
    check("R9 align warn", m_wa, 1);
    check("R9 no cks", m_cks, 0);
    check("R9 no last", m_last, 0);
    check("R9 no short", m_ws, 0);

    // R10 one byte beyond the limit
    build(MAXB + 1, 1, 2);
    clear_mon();
    pulse_sof();
    for (int i = 0; i < MAXB + 1; i++) send_byte(fb[i]);
    idle(2);
    check("R10 long warn", m_wl, 1);
    check("R10 data before limit", m_nd, MAXB - 6);
    clear_mon();
    send_byte(8'hA5);
    pulse_eof();
    idle(3);
    check("R10 nothing after", m_nd + m_cks + m_ws + m_wa + m_wl, 0);

    // R6 a fresh frame after discards decodes cleanly
    build(6, 1, 9);
    run_and_check(6, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule